// File: doc/BRIEF.md
# Flash Command Sequencer with Boot-Region Lockout

This block is a synchronous controller for a byte-wide flash array. The host issues single-cycle write strobes, each with a latched address and data byte. The block decodes these writes against fixed unlock sequences and starts one of three actions: a byte program, a whole-array erase, or a one-way lockout of a 16K-byte boot region.

Program and erase are timed inside the block by a cycle counter. While either is running the block reports busy and ignores all writes. Each started operation is issued as a one-cycle request to a small behavioural array held inside the block. The request pins let the surrounding logic observe the operation. A combinational read port brings the array contents out for inspection.

The boot region sits at the bottom or the top of a 1M-byte space, chosen by a parameter. Once the lockout is enabled, programs aimed at the boot region are dropped. An erase then clears only the main region. Only a reset of the block, which models power-on, clears the lockout; no command can undo it.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, busy, boot_locked, prog_req and erase_req are 0, and every array location reads 0xFF. Erased bits read as 1.
- R2: A program takes four accepted writes: address 0x05555 with data 0xAA, then 0x02AAA with 0x55, then 0x05555 with 0xA0, then the target address and data. In the cycle after the fourth write, prog_req is 1 for one cycle, and prog_addr and prog_data carry that write's address and data.
- R3: A program can only clear bits. The location then holds its old value ANDed with the new data.
- R4: busy goes to 1 in the cycle after the final write of a program or erase. It stays 1 for exactly PROG_CYC cycles after a program and ERASE_CYC cycles after an erase, then returns to 0.
- R5: A write that is not the expected next step returns the decoder to idle. A later write that would only complete the abandoned sequence starts nothing.
- R6: Writes made while busy is 1 are ignored and do not advance any sequence.
- R7: An erase takes six writes. The first two are the same as a program. The third is 0x80 to 0x05555, followed by 0xAA to 0x05555, 0x55 to 0x02AAA, and finally 0x10 to 0x05555. In the cycle after the last write, erase_req is 1 for one cycle, and afterwards every location reads 0xFF.
- R8: The same six-write sequence ending in 0x40 instead of 0x10 sets boot_locked. boot_locked then stays 1 until reset, and this sequence does not raise busy.
- R9: The boot region is 0x00000–0x03FFF with bottom placement (the default) and 0xFC000–0xFFFFF with top placement. While the block is locked, a program aimed at the boot region raises neither prog_req nor busy, and leaves the location's contents unchanged.
- R10: While the block is locked, an erase leaves the boot region's contents unchanged and sets the main region to 0xFF.
- R11: The array models two windows of 2**WIN_W bytes each, one at the lowest and one at the highest addresses. Programs outside both windows still raise prog_req and busy but store nothing. Reads outside both windows return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (models power-on) |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | 20 | Latched write address |
| wr_data | input | 8 | Latched write data |
| rd_addr | input | 20 | Array inspection address |
| rd_data | output | 8 | Array contents at rd_addr (combinational) |
| busy | output | 1 | Program or erase in progress |
| boot_locked | output | 1 | Boot-region lockout enabled |
| prog_req | output | 1 | One-cycle byte program request |
| prog_addr | output | 20 | Address of the last program request |
| prog_data | output | 8 | Data of the last program request |
| erase_req | output | 1 | One-cycle erase request |

## Verification
The bench programs the same location twice. A design that overwrote instead of ANDing would show the second byte unchanged rather than the AND of the two. It breaks a sequence at its second step and then sends the remaining steps. A decoder that failed to fall back to idle would start a stray program. It sends a complete program sequence while an earlier program is still busy; a design that kept decoding during busy would modify a second location. Finally, it locks the block and then programs and erases the boot region, which catches a design that either ignores the lock or applies it to the main region.

// File: rtl/flash_seq_pkg.sv
// Shared types and helpers for the flash command sequencer.
// Assumes a byte-wide array and an address space of at most 31 bits.
package flash_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,   // waiting for first unlock write
        SQ_U1,     // first unlock write seen
        SQ_U2,     // second unlock write seen
        SQ_PGM,    // next write carries program target
        SQ_X3,     // extended command code seen
        SQ_X4,     // extended first unlock seen
        SQ_X5      // extended second unlock seen
    } seq_state_t;

    // True when address a falls in the boot region of a 2**aw byte space.
    function automatic logic in_boot(input logic [31:0] a, input int aw,
                                     input int bytes, input bit top);
        logic [31:0] limit;
        limit = (32'(1) << aw) - 32'(bytes);
        return top ? (a >= limit) : (a < 32'(bytes));
    endfunction

endpackage

// File: rtl/fseq_decoder.sv
// Command sequence decoder. Walks the unlock steps on accepted writes and
// emits one-cycle start pulses for program, erase and lock.
// Assumes writes are single-cycle strobes; writes while busy are not accepted.
module fseq_decoder
    import flash_seq_pkg::*;
#(
    parameter int              ADDR_W     = 20,
    parameter int              DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR_A = 'h5555,
    parameter logic [ADDR_W-1:0] CMD_ADDR_B = 'h2AAA,
    parameter logic [DATA_W-1:0] UNLOCK_D1  = 'hAA,
    parameter logic [DATA_W-1:0] UNLOCK_D2  = 'h55,
    parameter logic [DATA_W-1:0] PGM_CODE   = 'hA0,
    parameter logic [DATA_W-1:0] EXT_CODE   = 'h80,
    parameter logic [DATA_W-1:0] ERASE_CODE = 'h10,
    parameter logic [DATA_W-1:0] LOCK_CODE  = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              start_prog,
    output logic              start_erase,
    output logic              set_lock
);

    seq_state_t state_q, state_d;
    logic       accept;

    assign accept = wr_en && !busy;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                                 input logic [ADDR_W-1:0] ea, input logic [DATA_W-1:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    // Next-state and start-pulse decode for one accepted write.
    always_comb begin
        state_d     = state_q;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        set_lock    = 1'b0;
        if (accept) begin
            state_d = SQ_IDLE;
            unique case (state_q)
                SQ_IDLE: if (hit(wr_addr, wr_data, CMD_ADDR_A, UNLOCK_D1)) state_d = SQ_U1;
                SQ_U1:   if (hit(wr_addr, wr_data, CMD_ADDR_B, UNLOCK_D2)) state_d = SQ_U2;
                SQ_U2: begin
                    if (hit(wr_addr, wr_data, CMD_ADDR_A, PGM_CODE))      state_d = SQ_PGM;
                    else if (hit(wr_addr, wr_data, CMD_ADDR_A, EXT_CODE)) state_d = SQ_X3;
                end
                SQ_PGM:  start_prog = 1'b1;
                SQ_X3:   if (hit(wr_addr, wr_data, CMD_ADDR_A, UNLOCK_D1)) state_d = SQ_X4;
                SQ_X4:   if (hit(wr_addr, wr_data, CMD_ADDR_B, UNLOCK_D2)) state_d = SQ_X5;
                SQ_X5: begin
                    start_erase = hit(wr_addr, wr_data, CMD_ADDR_A, ERASE_CODE);
                    set_lock    = hit(wr_addr, wr_data, CMD_ADDR_A, LOCK_CODE);
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // R6: no step is taken while an operation runs
    a_r6_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(state_q));

    // R5: at most one action starts per write
    a_r5_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_erase, set_lock}));

endmodule

// File: rtl/fseq_timer.sv
// Operation timer. Loads a cycle count when program or erase starts and
// holds busy until it has counted down to zero.
// Assumes loads arrive only while idle and both counts are at least 2.
module fseq_timer #(
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_prog,
    input  logic load_erase,
    output logic busy
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    // Countdown register: load on start, decrement to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load_prog)  cnt_q <= CNT_W'(PROG_CYC);
        else if (load_erase) cnt_q <= CNT_W'(ERASE_CYC);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R4: a new operation is only loaded when the previous one has ended
    a_r4_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (load_prog || load_erase) |-> !busy);

endmodule

// File: rtl/fseq_array.sv
// Behavioural byte array: two windows of 2**WIN_W bytes, one at the bottom
// and one at the top of the address space. Programs AND data in; erase sets
// 0xFF, optionally sparing boot-region bytes.
// Assumes program and erase requests are never issued in the same cycle.
module fseq_array
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 8,
    parameter int WIN_W      = 4,
    parameter int BOOT_BYTES = 16384,
    parameter bit BOOT_TOP   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic              keep_boot,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int WIN     = 1 << WIN_W;
    localparam int ENTRIES = 2 * WIN;

    logic [DATA_W-1:0] cell_q [ENTRIES];
    logic [ADDR_W-1:0] cell_addr [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
        localparam logic [31:0] BASE  = (i < WIN) ? 32'd0 : ((32'(1) << ADDR_W) - 32'(WIN));
        localparam logic [31:0] ADDR  = BASE + 32'(i % WIN);
        localparam bit          IS_BOOT = in_boot(ADDR, ADDR_W, BOOT_BYTES, BOOT_TOP);

        assign cell_addr[i] = ADDR[ADDR_W-1:0];

        // One byte cell: AND on program, set on erase unless spared.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q[i] <= '1;
            else if (erase_en && !(keep_boot && IS_BOOT))
                cell_q[i] <= '1;
            else if (prog_en && prog_addr == cell_addr[i])
                cell_q[i] <= cell_q[i] & prog_data;
        end

        if (IS_BOOT) begin : g_guard
            // R10: a locked erase leaves boot bytes untouched
            a_r10_boot_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (erase_en && keep_boot && !prog_en) |=> $stable(cell_q[i]));
        end
    end

    // Read mux: matching cell or erased value outside the windows.
    always_comb begin
        rd_data = '1;
        for (int i = 0; i < ENTRIES; i++)
            if (rd_addr == cell_addr[i]) rd_data = cell_q[i];
    end

endmodule

// File: rtl/flash_seq_ctrl.sv
// Flash command sequencer top. Decodes unlock sequences, applies the sticky
// boot-region lockout, times operations and drives the behavioural array.
// Assumes a synchronous active-low reset that models power-on; the lockout
// is cleared by nothing else.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 8,
    parameter int WIN_W      = 4,
    parameter int BOOT_BYTES = 16384,
    parameter bit BOOT_TOP   = 1'b0,
    parameter int PROG_CYC   = 64,
    parameter int ERASE_CYC  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              boot_locked,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_req
);

    logic start_prog, start_erase, set_lock;
    logic target_boot, prog_go;

    fseq_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy),
        .start_prog(start_prog), .start_erase(start_erase), .set_lock(set_lock)
    );

    assign target_boot = in_boot(32'(wr_addr), ADDR_W, BOOT_BYTES, BOOT_TOP);
    assign prog_go     = start_prog && !(boot_locked && target_boot);

    fseq_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .load_prog(prog_go), .load_erase(start_erase),
        .busy(busy)
    );

    // Sticky lockout flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        boot_locked <= 1'b0;
        else if (set_lock) boot_locked <= 1'b1;
    end

    // Request pulses and captured program target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_req  <= 1'b0;
            erase_req <= 1'b0;
            prog_addr <= '0;
            prog_data <= '0;
        end else begin
            prog_req  <= prog_go;
            erase_req <= start_erase;
            if (prog_go) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
        end
    end

    fseq_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W),
                 .BOOT_BYTES(BOOT_BYTES), .BOOT_TOP(BOOT_TOP)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .prog_en(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_en(erase_req), .keep_boot(boot_locked),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R8: the lockout never clears without reset
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        boot_locked |=> boot_locked);

    // R9: no program request reaches a locked boot byte
    a_r9_no_boot_req: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !(boot_locked && in_boot(32'(prog_addr), ADDR_W, BOOT_BYTES, BOOT_TOP)));

    // R2: every request is covered by a running operation
    a_r2_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || erase_req) |-> busy);

endmodule

// File: tb/sim_flash_seq_ctrl.sv
`timescale 1ns/1ps
module sim_flash_seq_ctrl;

    localparam int P = 6;
    localparam int E = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [19:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy, boot_locked, prog_req, erase_req;
    logic [19:0] prog_addr;
    logic [7:0]  prog_data;

    int n_tests = 0;
    int n_fail  = 0;

    flash_seq_ctrl #(.PROG_CYC(P), .ERASE_CYC(E)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .boot_locked(boot_locked),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_req(erase_req)
    );

    always #4 clk = ~clk;

    // vector: {addr[19:0], data[7:0], expected read[7:0]}
    localparam logic [35:0] VEC [6] = '{
        {20'h00003, 8'h5A, 8'h5A},
        {20'hFFFF1, 8'hC3, 8'hC3},
        {20'h00003, 8'h0F, 8'h0A},
        {20'hFFFFF, 8'h00, 8'h00},
        {20'h0000F, 8'hF0, 8'hF0},
        {20'hFFFF1, 8'h3C, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [19:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic pgm(input logic [19:0] a, input logic [7:0] d);
        wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0); wr(a, d);
    endtask

    task automatic ext(input logic [7:0] code);
        wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h80);
        wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, code);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 locked", boot_locked, 0);
        check("R1 reqs", {prog_req, erase_req}, 0);
        rd(20'h00003, v); check("R1 boot cell", v, 8'hFF);
        rd(20'hFFFF1, v); check("R1 main cell", v, 8'hFF);

        // R2/R3 table of programs
        for (int i = 0; i < 6; i++) begin
            pgm(VEC[i][35:16], VEC[i][15:8]);
            check("R2 prog_req", prog_req, 1);
            check("R2 prog_addr", prog_addr, VEC[i][35:16]);
            check("R2 prog_data", prog_data, VEC[i][15:8]);
            repeat (P) @(negedge clk);
            rd(VEC[i][35:16], v); check("R3 stored AND", v, VEC[i][7:0]);
        end

        // R4 program busy window, R11 outside window
        pgm(20'h40000, 8'h00);
        check("R4 busy start", busy, 1);
        check("R11 req outside", prog_req, 1);
        @(negedge clk);
        check("R2 pulse one cycle", prog_req, 0);
        repeat (P - 2) @(negedge clk);
        check("R4 busy last", busy, 1);
        @(negedge clk);
        check("R4 busy end", busy, 0);
        rd(20'h40000, v); check("R11 read outside", v, 8'hFF);

        // R5 broken sequence
        wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h54);
        wr(20'h05555, 8'hA0); wr(20'hFFFF2, 8'h00);
        check("R5 no busy", busy, 0);
        check("R5 no req", prog_req, 0);
        rd(20'hFFFF2, v); check("R5 cell unchanged", v, 8'hFF);

        // R6 writes during busy ignored
        pgm(20'hFFFF3, 8'h11);
        pgm(20'hFFFF4, 8'h00);
        repeat (P) @(negedge clk);
        check("R6 idle", busy, 0);
        rd(20'hFFFF4, v); check("R6 ignored cell", v, 8'hFF);
        rd(20'hFFFF3, v); check("R6 first prog", v, 8'h11);

        // R7 erase unlocked
        ext(8'h10);
        check("R7 erase_req", erase_req, 1);
        check("R4 erase busy", busy, 1);
        repeat (E - 1) @(negedge clk);
        check("R4 erase busy last", busy, 1);
        @(negedge clk);
        check("R4 erase end", busy, 0);
        rd(20'h00003, v); check("R7 boot erased", v, 8'hFF);
        rd(20'hFFFF3, v); check("R7 main erased", v, 8'hFF);

        // R8 lock
        pgm(20'h00005, 8'h12);
        repeat (P) @(negedge clk);
        ext(8'h40);
        check("R8 locked", boot_locked, 1);
        check("R8 no busy", busy, 0);

        // R9 locked boot program dropped; main still works
        pgm(20'h00005, 8'h00);
        check("R9 no req", prog_req, 0);
        check("R9 no busy", busy, 0);
        rd(20'h00005, v); check("R9 boot kept", v, 8'h12);
        pgm(20'hFFFF6, 8'h34);
        repeat (P) @(negedge clk);
        rd(20'hFFFF6, v); check("R9 main prog", v, 8'h34);

        // R10 locked erase spares boot
        ext(8'h10);
        repeat (E) @(negedge clk);
        rd(20'h00005, v); check("R10 boot kept", v, 8'h12);
        rd(20'hFFFF6, v); check("R10 main erased", v, 8'hFF);
        check("R8 still locked", boot_locked, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule